// File: doc/BRIEF.md
# Receiver Error Code Latch with Preamble Lock Tracking

This block sits behind the biphase decoder of a digital audio receiver. It watches the frame and block preamble strobes to decide whether the receiver is locked. It watches the per-subframe events for parity, biphase violations, the validity bit, confidence, slipped samples and channel-status CRC mismatches. It keeps a three-bit code holding the most serious condition seen since software-free clearing last took place. Clearing happens when the select input is held high for more than eight consecutive master-clock cycles. Errors that arrive while that hold is in progress are not lost.

For each completed subframe the block also registers an error flag and a flag that is the OR of that error flag and the received validity bit. Downstream interpolation can use the second flag to conceal unreliable samples. The CRC is computed elsewhere; only its mismatch indication enters here.

Top module: `rx_err_monitor`

## Requirements
- R1: While rst_n is low at a clock edge, err_code is 000, err_flag and verr_flag are 0 and locked is 0.
- R2: err_code holds the highest code raised since the last clear, where higher codes win: 001 validity bit set in a subframe, 010 confidence event, 011 slipped sample, 100 CRC mismatch, 101 parity error, 110 biphase violation, 111 not locked.
- R3: In every cycle in which locked is 0, code 111 is raised, so err_code reads 111 after the following edge.
- R4: locked goes high on a block preamble that follows at least three frame preambles, with no missed window or early block preamble in between. While locked, a window of FRAME_TICKS+TICK_TOL bit ticks (68 by default) with no preamble of either kind counts as one miss. The fourth consecutive miss drops locked on that edge.
- R5: When sub_valid is high, err_flag is set on that edge to 1 if any of these hold: the 28-bit subframe has odd parity (XOR of all bits is 1), a biphase violation occurred since the previous subframe strobe (inclusive of this cycle), or the block is not locked. Otherwise err_flag is set to 0. Between strobes err_flag holds.
- R6: On the same edge, verr_flag is set to the OR of err_flag's new value and the validity bit, which is sub_bits[24].
- R7: Holding sel_hold high for 9 consecutive edges clears err_code on the ninth edge. A hold of 8 edges or fewer clears nothing.
- R8: A CRC mismatch raises code 100 only when crc_bad, block_pre and cs_pro are all high in the same cycle. Otherwise crc_bad has no effect.
- R9: Codes raised during the first eight edges of a clearing hold, or on the clearing edge itself, remain in err_code after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_hold | input | 1 | Select input; a long high hold clears the code |
| bit_tick | input | 1 | One pulse per received bit cell |
| frame_pre | input | 1 | Frame preamble detected |
| block_pre | input | 1 | Block (channel-status start) preamble detected |
| sub_valid | input | 1 | Strobe: sub_bits holds a complete subframe |
| sub_bits | input | 28 | Subframe payload; bit 24 validity, bit 27 parity |
| bip_viol | input | 1 | Biphase coding violation pulse |
| conf_err | input | 1 | Confidence event pulse |
| slip_err | input | 1 | Slipped sample pulse |
| crc_bad | input | 1 | Channel-status CRC mismatch |
| cs_pro | input | 1 | Channel status is in professional format |
| err_code | output | 3 | Latched highest-priority error code |
| err_flag | output | 1 | Per-subframe error flag |
| verr_flag | output | 1 | Validity OR error flag |
| locked | output | 1 | Receiver lock status |

## Verification
The clearing edge of a select hold can coincide with a fresh error event. In that case the new code must survive, together with anything that arrived earlier in the hold. The bench forces this by raising a slipped-sample pulse exactly on the ninth high edge and by injecting a confidence event mid-hold, and expects 011 and 010 respectively instead of 000. Random runs with the select line toggling often also place preambles, subframe strobes and window expiries on clearing edges. Each edge there is judged against a cycle-accurate reference model kept in the bench.

// File: rtl/rx_err_pkg.sv
// Shared types for the receiver error monitor.
// Codes are ordered so that a numerically larger code is more serious.
package rx_err_pkg;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_VALID   = 3'd1,
        ERR_CONF    = 3'd2,
        ERR_SLIP    = 3'd3,
        ERR_CRC     = 3'd4,
        ERR_PARITY  = 3'd5,
        ERR_BIPHASE = 3'd6,
        ERR_NOLOCK  = 3'd7
    } err_code_e;

    localparam int ERR_W     = 3;
    localparam int ERR_COUNT = 8;

    // Larger of two codes, i.e. the more serious one.
    function automatic logic [ERR_W-1:0] code_max(input logic [ERR_W-1:0] a,
                                                  input logic [ERR_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rx_lock_track.sv
// Lock tracker.
// Gains lock when a block preamble arrives after ACQ_FRAMES frame preambles.
// While locked, every window of FRAME_TICKS+TICK_TOL bit ticks without any
// preamble is a miss; MISS_LIMIT consecutive misses drop lock.
// Assumes preamble strobes and bit_tick are single-cycle, synchronous pulses.
module rx_lock_track #(
    parameter int FRAME_TICKS = 64,
    parameter int TICK_TOL    = 4,
    parameter int ACQ_FRAMES  = 3,
    parameter int MISS_LIMIT  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic frame_pre,
    input  logic block_pre,
    output logic locked
);
    localparam int WIN = FRAME_TICKS + TICK_TOL;
    localparam int TW  = $clog2(WIN);
    localparam int AW  = $clog2(ACQ_FRAMES + 1);
    localparam int MW  = $clog2(MISS_LIMIT + 1);
    localparam logic [TW-1:0] T_LAST = TW'(WIN - 1);
    localparam logic [AW-1:0] A_FULL = AW'(ACQ_FRAMES);
    localparam logic [MW-1:0] M_LAST = MW'(MISS_LIMIT - 1);

    logic [TW-1:0] tick_cnt;
    logic [AW-1:0] acq_cnt;
    logic [MW-1:0] miss_cnt;
    logic          any_pre;
    logic          win_miss;

    assign any_pre  = frame_pre | block_pre;
    assign win_miss = !any_pre && bit_tick && (tick_cnt == T_LAST);

    // Window timer: bit ticks since the last preamble, restarting on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (any_pre || win_miss) begin
            tick_cnt <= '0;
        end else if (bit_tick) begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    // Lock state: acquisition count while unlocked, miss count while locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked   <= 1'b0;
            acq_cnt  <= '0;
            miss_cnt <= '0;
        end else if (!locked) begin
            miss_cnt <= '0;
            if (block_pre) begin
                acq_cnt <= '0;
                if (acq_cnt >= A_FULL) locked <= 1'b1;
            end else if (frame_pre) begin
                if (acq_cnt < A_FULL) acq_cnt <= acq_cnt + 1'b1;
            end else if (win_miss) begin
                acq_cnt <= '0;
            end
        end else begin
            acq_cnt <= '0;
            if (any_pre) begin
                miss_cnt <= '0;
            end else if (win_miss) begin
                if (miss_cnt == M_LAST) begin
                    locked   <= 1'b0;
                    miss_cnt <= '0;
                end else begin
                    miss_cnt <= miss_cnt + 1'b1;
                end
            end
        end
    end

    // R4
    lock_needs_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !block_pre) |=> !locked);

    // R4
    lock_kept_on_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && any_pre) |=> locked);

    // R4
    timer_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt <= T_LAST);

endmodule

// File: rtl/rx_sample_flags.sv
// Per-subframe flags.
// Computes subframe parity, collects biphase violations between strobes and
// registers the error flag and validity-or-error flag on each strobe.
// Assumes sub_bits is stable and complete in the sub_valid cycle.
module rx_sample_flags #(
    parameter int SUB_W   = 28,
    parameter int VAL_POS = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sub_valid,
    input  logic [SUB_W-1:0] sub_bits,
    input  logic             bip_viol,
    input  logic             locked,
    output logic             parity_bad,
    output logic             val_bit,
    output logic             err_flag,
    output logic             verr_flag
);
    logic bip_pend;
    logic sample_err;

    assign parity_bad = ^sub_bits;
    assign val_bit    = sub_bits[VAL_POS];
    assign sample_err = parity_bad | bip_pend | bip_viol | !locked;

    // Biphase violation memory, emptied on every subframe strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bip_pend <= 1'b0;
        end else if (sub_valid) begin
            bip_pend <= 1'b0;
        end else if (bip_viol) begin
            bip_pend <= 1'b1;
        end
    end

    // Flag registers, updated once per subframe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag  <= 1'b0;
            verr_flag <= 1'b0;
        end else if (sub_valid) begin
            err_flag  <= sample_err;
            verr_flag <= sample_err | val_bit;
        end
    end

    // R6
    verr_covers_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> verr_flag);

    // R5
    unlocked_sample_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && !locked) |=> err_flag);

    // R5
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_valid |=> ($stable(err_flag) && $stable(verr_flag)));

endmodule

// File: rtl/rx_err_latch.sv
// Prioritised sticky error code.
// Encodes the events of the current cycle into one code, keeps the maximum
// since the last clear and clears after sel_hold has been high for more than
// CLR_HOLD edges. Events seen during the hold survive the clear.
// Assumes event inputs are synchronous single-cycle pulses or levels.
module rx_err_latch
    import rx_err_pkg::*;
#(
    parameter int CLR_HOLD = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_hold,
    input  logic             sub_valid,
    input  logic             val_bit,
    input  logic             parity_bad,
    input  logic             conf_err,
    input  logic             slip_err,
    input  logic             crc_bad,
    input  logic             block_pre,
    input  logic             cs_pro,
    input  logic             bip_viol,
    input  logic             locked,
    output logic [ERR_W-1:0] err_code
);
    localparam int CW = $clog2(CLR_HOLD + 2);
    localparam logic [CW-1:0] C_FIRE = CW'(CLR_HOLD);
    localparam logic [CW-1:0] C_DONE = CW'(CLR_HOLD + 1);

    logic [ERR_COUNT-1:0] req;
    logic [ERR_W-1:0]     cand;
    logic [ERR_W-1:0]     win_code;
    logic [CW-1:0]        hold_cnt;
    logic                 clear_now;

    // Request vector, one bit per code.
    always_comb begin
        req              = '0;
        req[ERR_NONE]    = 1'b1;
        req[ERR_VALID]   = sub_valid & val_bit;
        req[ERR_CONF]    = conf_err;
        req[ERR_SLIP]    = slip_err;
        req[ERR_CRC]     = crc_bad & block_pre & cs_pro;
        req[ERR_PARITY]  = sub_valid & parity_bad;
        req[ERR_BIPHASE] = bip_viol;
        req[ERR_NOLOCK]  = !locked;
    end

    // Priority encoder: highest requesting code wins.
    always_comb begin
        cand = ERR_NONE;
        for (int i = 1; i < ERR_COUNT; i++) begin
            if (req[i]) cand = ERR_W'(i);
        end
    end

    assign clear_now = sel_hold && (hold_cnt == C_FIRE);

    // Hold timer: consecutive high edges of sel_hold, saturating after firing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (!sel_hold) begin
            hold_cnt <= '0;
        end else if (hold_cnt != C_DONE) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    // Sticky code plus shadow of events arriving inside the hold window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_code <= ERR_NONE;
            win_code <= ERR_NONE;
        end else if (clear_now) begin
            err_code <= code_max(win_code, cand);
            win_code <= ERR_NONE;
        end else begin
            err_code <= code_max(err_code, cand);
            if (sel_hold && hold_cnt < C_FIRE) win_code <= code_max(win_code, cand);
            else                               win_code <= ERR_NONE;
        end
    end

    // R2
    code_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_now |=> err_code >= $past(err_code));

    // R3
    nolock_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> err_code == ERR_NOLOCK);

    // R9
    clear_keeps_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_now |=> err_code >= $past(win_code));

    // R7
    short_hold_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_hold && hold_cnt < C_FIRE) |=> err_code >= $past(err_code));

endmodule

// File: rtl/rx_err_monitor.sv
// Receiver error monitor top.
// Ties the lock tracker, the per-subframe flag unit and the sticky code latch.
// Assumes all inputs are synchronous to clk.
module rx_err_monitor
    import rx_err_pkg::*;
#(
    parameter int SUB_W       = 28,
    parameter int VAL_POS     = 24,
    parameter int FRAME_TICKS = 64,
    parameter int TICK_TOL    = 4,
    parameter int ACQ_FRAMES  = 3,
    parameter int MISS_LIMIT  = 4,
    parameter int CLR_HOLD    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_hold,
    input  logic             bit_tick,
    input  logic             frame_pre,
    input  logic             block_pre,
    input  logic             sub_valid,
    input  logic [SUB_W-1:0] sub_bits,
    input  logic             bip_viol,
    input  logic             conf_err,
    input  logic             slip_err,
    input  logic             crc_bad,
    input  logic             cs_pro,
    output logic [2:0]       err_code,
    output logic             err_flag,
    output logic             verr_flag,
    output logic             locked
);
    logic parity_bad;
    logic val_bit;

    rx_lock_track #(
        .FRAME_TICKS(FRAME_TICKS),
        .TICK_TOL   (TICK_TOL),
        .ACQ_FRAMES (ACQ_FRAMES),
        .MISS_LIMIT (MISS_LIMIT)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .frame_pre(frame_pre),
        .block_pre(block_pre),
        .locked   (locked)
    );

    rx_sample_flags #(
        .SUB_W  (SUB_W),
        .VAL_POS(VAL_POS)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .sub_valid (sub_valid),
        .sub_bits  (sub_bits),
        .bip_viol  (bip_viol),
        .locked    (locked),
        .parity_bad(parity_bad),
        .val_bit   (val_bit),
        .err_flag  (err_flag),
        .verr_flag (verr_flag)
    );

    rx_err_latch #(
        .CLR_HOLD(CLR_HOLD)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_hold  (sel_hold),
        .sub_valid (sub_valid),
        .val_bit   (val_bit),
        .parity_bad(parity_bad),
        .conf_err  (conf_err),
        .slip_err  (slip_err),
        .crc_bad   (crc_bad),
        .block_pre (block_pre),
        .cs_pro    (cs_pro),
        .bip_viol  (bip_viol),
        .locked    (locked),
        .err_code  (err_code)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (err_code == 3'd0 || !$past(!rst_n)) );

endmodule

// File: tb/test_rx_err_monitor.sv
// Self-checking bench: directed corner cases plus seeded random stimulus,
// every edge compared against a reference model written from the requirements.
module test_rx_err_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 68;
    localparam int HOLD       = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_hold = 0, bit_tick = 0, fp_d = 0, auto_pre = 0, block_pre = 0;
    logic        sub_valid = 0, bip_viol = 0, conf_err = 0, slip_err = 0;
    logic        crc_bad = 0, cs_pro = 0;
    logic [27:0] sub_bits = '0;
    logic        frame_pre;
    logic [2:0]  err_code;
    logic        err_flag, verr_flag, locked;

    int checks = 0, errors = 0;
    int keep_lock = 0, auto_cnt = 0;

    // reference model state
    int m_t = 0, m_acq = 0, m_miss = 0, m_s = 0;
    logic m_lock = 0, m_bip = 0, m_ef = 0, m_vf = 0;
    logic [2:0] m_code = 0, m_win = 0;

    assign frame_pre = fp_d | auto_pre;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_err_monitor i_rx_err_monitor (
        .clk(clk), .rst_n(rst_n), .sel_hold(sel_hold), .bit_tick(bit_tick),
        .frame_pre(frame_pre), .block_pre(block_pre), .sub_valid(sub_valid),
        .sub_bits(sub_bits), .bip_viol(bip_viol), .conf_err(conf_err),
        .slip_err(slip_err), .crc_bad(crc_bad), .cs_pro(cs_pro),
        .err_code(err_code), .err_flag(err_flag), .verr_flag(verr_flag),
        .locked(locked));

    function automatic logic [2:0] mx(input logic [2:0] a, input logic [2:0] b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: one clock edge using the inputs present before it.
    task automatic model_step();
        logic pre, miss, perr, ev;
        logic [2:0] c;
        int nt, nacq, nmiss, ns;
        logic nl, nbip, clr;
        if (!rst_n) begin
            m_t = 0; m_acq = 0; m_miss = 0; m_s = 0; m_lock = 0; m_bip = 0;
            m_ef = 0; m_vf = 0; m_code = 0; m_win = 0;
            return;
        end
        pre  = frame_pre | block_pre;
        miss = !pre && bit_tick && (m_t == WIN-1);
        nt   = (pre || miss) ? 0 : (bit_tick ? m_t + 1 : m_t);
        nl = m_lock; nacq = m_acq; nmiss = m_miss;
        if (!m_lock) begin
            nmiss = 0;
            if (block_pre) begin nl = (m_acq >= 3); nacq = 0; end
            else if (frame_pre) nacq = (m_acq < 3) ? m_acq + 1 : 3;
            else if (miss) nacq = 0;
        end else begin
            nacq = 0;
            if (pre) nmiss = 0;
            else if (miss) begin
                if (m_miss == 3) begin nl = 0; nmiss = 0; end
                else nmiss = m_miss + 1;
            end
        end
        perr = ^sub_bits;
        ev   = perr | m_bip | bip_viol | !m_lock;
        if (sub_valid) begin m_ef = ev; m_vf = ev | sub_bits[24]; end
        nbip = sub_valid ? 1'b0 : (bip_viol ? 1'b1 : m_bip);
        c = 0;
        if (sub_valid && sub_bits[24]) c = 1;
        if (conf_err) c = 2;
        if (slip_err) c = 3;
        if (crc_bad && block_pre && cs_pro) c = 4;
        if (sub_valid && perr) c = 5;
        if (bip_viol) c = 6;
        if (!m_lock) c = 7;
        clr = sel_hold && (m_s == HOLD);
        ns  = !sel_hold ? 0 : ((m_s == HOLD+1) ? HOLD+1 : m_s + 1);
        if (clr) begin m_code = mx(m_win, c); m_win = 0; end
        else begin
            m_code = mx(m_code, c);
            m_win  = (sel_hold && m_s < HOLD) ? mx(m_win, c) : 3'd0;
        end
        m_t = nt; m_acq = nacq; m_miss = nmiss; m_lock = nl; m_bip = nbip; m_s = ns;
    endtask

    task automatic cyc();
        if (keep_lock != 0 && auto_cnt == 31) auto_pre = 1'b1;
        @(posedge clk);
        model_step();
        #1;
        chk("R2 err_code vs model", err_code, m_code);
        chk("R4 locked vs model", locked, m_lock);
        chk("R5 err_flag vs model", err_flag, m_ef);
        chk("R6 verr_flag vs model", verr_flag, m_vf);
        auto_pre = 1'b0;
        auto_cnt = (keep_lock != 0) ? ((auto_cnt == 31) ? 0 : auto_cnt + 1) : 0;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic send_sub(input logic [27:0] b);
        sub_bits = b; sub_valid = 1; cyc(); sub_valid = 0; sub_bits = '0;
    endtask

    task automatic clear_code();
        sel_hold = 1; cycles(HOLD + 1); sel_hold = 0; cyc();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run hung (actual running, expected finished)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20241));
        bit_tick = 1;
        // R1: reset state
        cycles(3);
        chk("R1 err_code in reset", err_code, 0);
        chk("R1 locked in reset", locked, 0);
        chk("R1 err_flag in reset", err_flag, 0);
        chk("R1 verr_flag in reset", verr_flag, 0);
        rst_n = 1;
        cyc();
        chk("R3 unlocked gives 7", err_code, 7);

        // R4: acquisition, three frames then a block
        for (int k = 0; k < 3; k++) begin
            fp_d = 1; cyc(); fp_d = 0; cycles(10);
        end
        chk("R4 not locked before block", locked, 0);
        block_pre = 1; cyc(); block_pre = 0;
        chk("R4 locked after block", locked, 1);
        keep_lock = 1;
        cycles(3);

        // R7: eight-edge hold does not clear, ninth does
        sel_hold = 1; cycles(HOLD);
        chk("R7 no clear after 8 edges", err_code, 7);
        cyc();
        chk("R7 clear on 9th edge", err_code, 0);
        sel_hold = 0; cyc();

        // R2 / R5 / R6: priority ordering and sample flags
        send_sub(28'h1000001);
        chk("R2 validity code", err_code, 1);
        chk("R5 good subframe", err_flag, 0);
        chk("R6 validity sets verr", verr_flag, 1);
        conf_err = 1; cyc(); conf_err = 0;
        chk("R2 confidence code", err_code, 2);
        send_sub(28'h1000001);
        chk("R2 lower code does not replace", err_code, 2);
        send_sub(28'h0000001);
        chk("R2 parity code", err_code, 5);
        chk("R5 odd parity flag", err_flag, 1);
        chk("R6 error sets verr", verr_flag, 1);
        slip_err = 1; cyc(); slip_err = 0;
        chk("R2 slip below parity", err_code, 5);
        bip_viol = 1; cyc(); bip_viol = 0; cycles(2);
        chk("R2 biphase code", err_code, 6);
        send_sub(28'h0000000);
        chk("R5 held biphase flags sample", err_flag, 1);
        send_sub(28'h0000000);
        chk("R5 clean sample", err_flag, 0);
        chk("R6 clean verr", verr_flag, 0);

        // R8: CRC only at block start in professional format
        clear_code();
        cs_pro = 0; crc_bad = 1; block_pre = 1; cyc(); block_pre = 0; crc_bad = 0;
        chk("R8 consumer crc ignored", err_code, 0);
        cs_pro = 1; crc_bad = 1; cyc(); crc_bad = 0;
        chk("R8 crc without block ignored", err_code, 0);
        crc_bad = 1; block_pre = 1; cyc(); block_pre = 0; crc_bad = 0; cs_pro = 0;
        chk("R8 professional crc at block", err_code, 4);

        // R9: events inside the hold window survive the clear
        sel_hold = 1; cycles(3);
        conf_err = 1; cyc(); conf_err = 0;
        cycles(HOLD - 4);
        cyc();
        chk("R9 mid-hold event kept", err_code, 2);
        sel_hold = 0; cyc();
        clear_code();
        sel_hold = 1; cycles(HOLD);
        slip_err = 1; cyc(); slip_err = 0;
        chk("R9 event on clearing edge kept", err_code, 3);
        sel_hold = 0; cyc();

        // R7: two short holds do not add up
        sel_hold = 1; cycles(HOLD); sel_hold = 0; cyc();
        sel_hold = 1; cycles(HOLD); sel_hold = 0; cyc();
        chk("R7 split holds no clear", err_code, 3);

        // R4: loss after four missed windows
        keep_lock = 0;
        fp_d = 1; cyc(); fp_d = 0;
        cycles(4 * WIN - 1);
        chk("R4 still locked before 4th miss", locked, 1);
        cyc();
        chk("R4 lock lost on 4th miss", locked, 0);
        cyc();
        chk("R3 lost lock gives 7", err_code, 7);

        // random phase
        for (int n = 0; n < 6000; n++) begin
            bit_tick  = ($urandom % 4) != 0;
            fp_d      = ($urandom % 40) == 0;
            block_pre = ($urandom % 300) == 0;
            sub_valid = ($urandom % 12) == 0;
            sub_bits  = 28'($urandom);
            bip_viol  = ($urandom % 150) == 0;
            conf_err  = ($urandom % 200) == 0;
            slip_err  = ($urandom % 200) == 0;
            crc_bad   = $urandom % 2;
            cs_pro    = $urandom % 2;
            if (($urandom % 12) == 0) sel_hold = ~sel_hold;
            cyc();
        end
        fp_d = 0; block_pre = 0; sub_valid = 0; bip_viol = 0;
        conf_err = 0; slip_err = 0; crc_bad = 0; sel_hold = 0;
        cycles(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule